// File: doc/BRIEF.md
# Chained Page-Bounded DMA Engine

This block is a single-channel bus-master DMA engine. It moves 32-bit words between one I/O device port and memory while the processor does other work. Software sets it up through a small register window. It loads a queue of up to eight transfer descriptors, each holding a memory address, a byte count and an end-of-chain flag. It then writes a control word that selects the direction, the device identity and interrupt enabling, and starts the chain.

For each descriptor, the engine first checks that the segment stays inside one 4 KiB memory page. It then requests the shared bus and waits for the grant. Once it holds the bus, it moves one word in every cycle in which the device reports it is ready. When the segment ends, it releases the bus. It raises a single completion flag after the last descriptor of the chain. A rejected descriptor stops the chain at once and reports its index. An interrupt line follows the completion and error flags, gated by an enable bit.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, the status word reads 0, `irq` is 0, `bus_req` is 0 and no memory access is made.
- R2: A write to offset 0x0 while idle stores the control fields: bit 1 is the direction (0 means device to memory, 1 means memory to device), bit 2 enables the interrupt, and bits 7:4 hold the device identity, which is driven on `dev_id`. If bit 0 of the same write is 1, the chain starts.
- R3: A write to offset 0x8 stages a descriptor address. A write to offset 0xC appends a descriptor made of that staged address, the length in bits 12:0 and the last flag in bit 31. At most 8 descriptors are held, and further appends are dropped. Offset 0x8 reads back the number of queued descriptors. The queue empties when the chain ends.
- R4: A memory access (`mem_valid`) happens only while `bus_gnt` is high, and only after `bus_req` was already high in the previous cycle.
- R5: Exactly one word moves in each cycle in which the engine holds the bus and `dev_ready` is 1. No word moves when `dev_ready` is 0. Within a segment, the address rises by 4 per word.
- R6: `bus_req` falls for at least one cycle between two segments, so each segment arbitrates for the bus anew.
- R7: A descriptor is rejected if its address is not word aligned, if its length is zero or not a multiple of 4, or if its in-page offset plus its length exceeds 4096. A start with an empty queue is also rejected. On rejection, the error flag is set and the index of the failing descriptor is recorded. That descriptor makes no memory access, the rest of the chain is dropped, and the engine returns to idle.
- R8: The done flag is set once, only after the last descriptor has finished. The last descriptor is the one with the last flag set, or the final queued entry. Earlier segments set no flag.
- R9: The status word at offset 0x4 has this layout: bit 0 busy, bit 1 done, bit 2 error, bit 3 overrun, bits 6:4 failing index. Writing 1 to bits 1 to 3 clears them.
- R10: `irq` equals the interrupt enable ANDed with (done OR error).
- R11: A write of start to offset 0x0 while busy is ignored and leaves the control fields unchanged, but it sets the overrun bit.
- R12: In device-to-memory mode, device words are stored at consecutive addresses. In memory-to-device mode, memory words are presented on `dev_wdata`, in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Data written to memory |
| mem_rdata | input | 32 | Data read from memory, same cycle |
| dev_id | output | 4 | Selected device identity |
| dev_ready | input | 1 | Device can deliver or accept a word |
| dev_rdata | input | 32 | Word offered by the device |
| dev_strobe | output | 1 | A word moves this cycle |
| dev_wdata | output | 32 | Word delivered to the device |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things. Memory answers a read in the same cycle. Once the grant arrives, it stays high for as long as `bus_req` is held. Software writes the queue only while the engine is idle. The bench meets all three. Its arbiter grants one half-cycle after a request and withdraws the grant one half-cycle after the request falls. Its memory model is a combinational array. Every descriptor append and control write is issued only after the status word reads idle. The one exception is the deliberate start-while-busy write, and that write touches only the control offset.

// File: rtl/dma_pkg.sv
package dma_pkg;
  parameter int ADDR_W    = 32;
  parameter int DATA_W    = 32;
  parameter int PAGE_BITS = 12;
  parameter int QDEPTH    = 8;

  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int LEN_W     = PAGE_BITS + 1;
  localparam int SUM_W     = PAGE_BITS + 2;
  localparam int QIW       = $clog2(QDEPTH);
  localparam int QCW       = $clog2(QDEPTH + 1);
  localparam int BYTES_W   = DATA_W / 8;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_REQ, S_XFER, S_GAP
  } seq_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              last;
  } seg_desc_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy_i,
  input  logic              done_set_i,
  input  logic              err_set_i,
  input  logic [QIW-1:0]    fail_idx_i,
  input  logic              q_clear_i,
  input  logic [QIW-1:0]    rd_idx_i,
  output seg_desc_t         desc_o,
  output logic [QCW-1:0]    q_count_o,
  output logic              start_o,
  output logic              dir_o,
  output logic [3:0]        dev_id_o,
  output logic              irq_o
);
  logic            dir_q, dir_d, ien_q, ien_d;
  logic [3:0]      id_q, id_d;
  logic [ADDR_W-1:0] stg_q, stg_d;
  logic [QCW-1:0]  cnt_q, cnt_d;
  logic            done_q, done_d, err_q, err_d, ovr_q, ovr_d;
  logic [QIW-1:0]  fidx_q, fidx_d;
  seg_desc_t       qmem [QDEPTH];
  logic            wr_ctrl, wr_stat, wr_stage, wr_push, start_wr;

  assign wr_ctrl  = reg_we && (reg_addr == 4'h0);
  assign wr_stat  = reg_we && (reg_addr == 4'h4);
  assign wr_stage = reg_we && (reg_addr == 4'h8) && !busy_i;
  assign wr_push  = reg_we && (reg_addr == 4'hC) && !busy_i && (cnt_q < QCW'(QDEPTH));
  assign start_wr = wr_ctrl && reg_wdata[0];
  assign start_o  = start_wr && !busy_i;

  always_comb begin
    dir_d = dir_q; ien_d = ien_q; id_d = id_q; stg_d = stg_q; cnt_d = cnt_q;
    done_d = done_q; err_d = err_q; ovr_d = ovr_q; fidx_d = fidx_q;
    if (wr_ctrl && !busy_i) begin
      dir_d = reg_wdata[1];
      ien_d = reg_wdata[2];
      id_d  = reg_wdata[7:4];
    end
    if (start_wr && busy_i) ovr_d = 1'b1;
    if (wr_stage) stg_d = reg_wdata;
    if (wr_push) cnt_d = cnt_q + QCW'(1);
    if (q_clear_i) cnt_d = '0;
    if (wr_stat) begin
      if (reg_wdata[1]) done_d = 1'b0;
      if (reg_wdata[2]) err_d  = 1'b0;
      if (reg_wdata[3]) ovr_d  = 1'b0;
    end
    if (done_set_i) done_d = 1'b1;
    if (err_set_i) begin
      err_d  = 1'b1;
      fidx_d = fail_idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0; ien_q <= 1'b0; id_q <= '0; stg_q <= '0; cnt_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; ovr_q <= 1'b0; fidx_q <= '0;
    end else begin
      dir_q <= dir_d; ien_q <= ien_d; id_q <= id_d; stg_q <= stg_d; cnt_q <= cnt_d;
      done_q <= done_d; err_q <= err_d; ovr_q <= ovr_d; fidx_q <= fidx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QDEPTH; i++) qmem[i] <= '0;
    end else if (wr_push) begin
      qmem[cnt_q[QIW-1:0]] <= '{addr: stg_q, len: reg_wdata[LEN_W-1:0], last: reg_wdata[31]};
    end
  end

  assign desc_o    = qmem[rd_idx_i];
  assign q_count_o = cnt_q;
  assign dir_o     = dir_q;
  assign dev_id_o  = id_q;
  assign irq_o     = ien_q && (done_q || err_q);

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = {24'd0, id_q, 1'b0, ien_q, dir_q, 1'b0};
      4'h4:    reg_rdata = {25'd0, 3'(fidx_q), ovr_q, err_q, done_q, busy_i};
      4'h8:    reg_rdata = 32'(cnt_q);
      default: reg_rdata = '0;
    endcase
  end

  // R11: start while busy leaves a sticky overrun mark
  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && busy_i) |=> ovr_q);

  // R3: queue occupancy never exceeds its depth
  p_queue_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= QCW'(QDEPTH));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  seg_desc_t          desc_i,
  input  logic [QCW-1:0]     q_count_i,
  input  logic               dir_i,
  output logic [QIW-1:0]     rd_idx_o,
  output logic               busy_o,
  output logic               done_set_o,
  output logic               err_set_o,
  output logic               q_clear_o,
  output logic               bus_req_o,
  input  logic               bus_gnt_i,
  output logic               mem_valid_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  input  logic               dev_ready_i,
  input  logic [DATA_W-1:0]  dev_rdata_i,
  output logic               dev_strobe_o,
  output logic [DATA_W-1:0]  dev_wdata_o
);
  seq_state_t        state_q, state_d;
  logic [QIW-1:0]    idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              last_q, last_d;
  logic              move, bad, empty;

  assign move  = (state_q == S_XFER) && bus_gnt_i && dev_ready_i;
  assign empty = QCW'(idx_q) >= q_count_i;
  assign bad   = (desc_i.len == '0) || (desc_i.len[1:0] != 2'b00) ||
                 (desc_i.addr[1:0] != 2'b00) ||
                 ((SUM_W'(desc_i.addr[PAGE_BITS-1:0]) + SUM_W'(desc_i.len)) > SUM_W'(PAGE_SIZE));

  always_comb begin
    state_d = state_q; idx_d = idx_q; addr_d = addr_q; rem_d = rem_q; last_d = last_q;
    done_set_o = 1'b0; err_set_o = 1'b0; q_clear_o = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        idx_d = '0;
        state_d = S_CHECK;
      end
      S_CHECK: if (empty || bad) begin
        err_set_o = 1'b1;
        q_clear_o = 1'b1;
        state_d   = S_IDLE;
      end else begin
        addr_d  = desc_i.addr;
        rem_d   = desc_i.len;
        last_d  = desc_i.last || ((QCW'(idx_q) + QCW'(1)) == q_count_i);
        state_d = S_REQ;
      end
      S_REQ: if (bus_gnt_i) state_d = S_XFER;
      S_XFER: if (move) begin
        addr_d = addr_q + ADDR_W'(BYTES_W);
        rem_d  = rem_q - LEN_W'(BYTES_W);
        if (rem_q == LEN_W'(BYTES_W)) state_d = S_GAP;
      end
      S_GAP: if (last_q) begin
        done_set_o = 1'b1;
        q_clear_o  = 1'b1;
        state_d    = S_IDLE;
      end else begin
        idx_d   = idx_q + QIW'(1);
        state_d = S_CHECK;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; idx_q <= '0; addr_q <= '0; rem_q <= '0; last_q <= 1'b0;
    end else begin
      state_q <= state_d; idx_q <= idx_d; addr_q <= addr_d; rem_q <= rem_d; last_q <= last_d;
    end
  end

  assign rd_idx_o     = idx_q;
  assign busy_o       = state_q != S_IDLE;
  assign bus_req_o    = (state_q == S_REQ) || (state_q == S_XFER);
  assign mem_valid_o  = move;
  assign mem_we_o     = move && !dir_i;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = dev_rdata_i;
  assign dev_strobe_o = move;
  assign dev_wdata_o  = mem_rdata_i;

  // R4: an access is preceded by a request already held in the prior cycle
  p_req_before_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> (bus_gnt_i && $past(bus_req_o)));

  // R5: back-to-back words walk the address upward by one word
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && $past(mem_valid_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(BYTES_W)));

  // R7: a rejection returns the engine to idle in the next cycle
  p_err_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_o |=> !busy_o);
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [3:0]  dev_id,
  input  logic        dev_ready,
  input  logic [31:0] dev_rdata,
  output logic        dev_strobe,
  output logic [31:0] dev_wdata,
  output logic        irq
);
  seg_desc_t      desc;
  logic [QCW-1:0] q_count;
  logic [QIW-1:0] rd_idx;
  logic           busy, done_set, err_set, q_clear, start, dir;

  dma_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .busy_i(busy), .done_set_i(done_set), .err_set_i(err_set), .fail_idx_i(rd_idx),
    .q_clear_i(q_clear), .rd_idx_i(rd_idx), .desc_o(desc), .q_count_o(q_count),
    .start_o(start), .dir_o(dir), .dev_id_o(dev_id), .irq_o(irq)
  );

  dma_seq u_seq (
    .clk, .rst_n, .start_i(start), .desc_i(desc), .q_count_i(q_count), .dir_i(dir),
    .rd_idx_o(rd_idx), .busy_o(busy), .done_set_o(done_set), .err_set_o(err_set),
    .q_clear_o(q_clear), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .dev_ready_i(dev_ready),
    .dev_rdata_i(dev_rdata), .dev_strobe_o(dev_strobe), .dev_wdata_o(dev_wdata)
  );
endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic bus_req, bus_gnt = 1'b0;
  logic mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] dev_id;
  logic dev_ready = 1'b0;
  logic [31:0] dev_rdata, dev_wdata;
  logic dev_strobe, irq;

  int checks = 0, fails = 0;
  logic stall = 1'b0;
  int cyc = 0, dev_cnt = 0, irq_rises = 0, req_rises = 0, bad_acc = 0, strobes = 0, dlog_n = 0;
  logic irq_p = 1'b0, req_p = 1'b0;
  logic [31:0] mem [2048];
  logic [31:0] dlog [64];

  always #4 clk = ~clk;

  dma_chain_engine dut_i (.*);

  assign mem_rdata = mem[mem_addr[12:2]];
  assign dev_rdata = 32'hA000_0000 + 32'(dev_cnt);

  always @(posedge clk) begin
    if (mem_valid && mem_we) mem[mem_addr[12:2]] <= mem_wdata;
    if (dev_strobe) dev_cnt <= dev_cnt + 1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (irq && !irq_p) irq_rises <= irq_rises + 1;
      if (bus_req && !req_p) req_rises <= req_rises + 1;
      if (mem_valid && (!bus_gnt || !dev_ready)) bad_acc <= bad_acc + 1;
      if (dev_strobe) begin
        strobes <= strobes + 1;
        if (dlog_n < 64) dlog[dlog_n] <= dev_wdata;
        dlog_n <= dlog_n + 1;
      end
    end
    irq_p <= irq;
    req_p <= bus_req;
    bus_gnt <= bus_req;
    dev_ready <= stall ? (cyc % 3 == 0) : 1'b1;
  end

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 4'h4;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 4'h4;
  endtask

  task automatic push(input logic [31:0] a, input int len, input bit last);
    wr(4'h8, a);
    wr(4'hC, {last, 18'd0, 13'(len)});
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(4'h4, s);
      if (!s[0]) break;
    end
  endtask

  task automatic clear_all();
    wr(4'h4, 32'hE);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(4'h4, s);
    chk(s == 0, "R1 status", s, 0);
    chk(!irq && !bus_req, "R1 irq/req", {irq, bus_req}, 0);
  endtask

  task automatic t_single();
    logic [31:0] s; int base;
    push(32'h100, 16, 1'b1);
    rd(4'h8, s);
    chk(s == 1, "R3 count", s, 1);
    base = dev_cnt;
    wr(4'h0, 32'h55);
    chk(dev_id == 4'h5, "R2 dev_id", 32'(dev_id), 5);
    wait_idle();
    for (int k = 0; k < 4; k++)
      chk(mem[64 + k] == 32'hA000_0000 + 32'(base + k), "R12 d2m word", mem[64 + k], 32'hA000_0000 + 32'(base + k));
    rd(4'h4, s);
    chk(s == 32'h2, "R9 done status", s, 32'h2);
    chk(irq == 1'b1, "R10 irq on done", 32'(irq), 1);
    rd(4'h8, s);
    chk(s == 0, "R3 queue emptied", s, 0);
    clear_all();
    rd(4'h4, s);
    chk(s == 0, "R9 w1c", s, 0);
    chk(irq == 1'b0, "R10 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_chain();
    int ir, rr, st, base;
    stall = 1'b1;
    push(32'h200, 8, 1'b0);
    push(32'h400, 12, 1'b0);
    push(32'h800, 4, 1'b1);
    ir = irq_rises; rr = req_rises; st = strobes; base = dev_cnt;
    wr(4'h0, 32'h05);
    wait_idle();
    @(negedge clk);
    chk(irq_rises - ir == 1, "R8 one irq per chain", 32'(irq_rises - ir), 1);
    chk(req_rises - rr == 3, "R6 rearbitrate per segment", 32'(req_rises - rr), 3);
    chk(strobes - st == 6, "R5 word count", 32'(strobes - st), 6);
    chk(bad_acc == 0, "R4 R5 access without grant or ready", 32'(bad_acc), 0);
    chk(mem[128 + 1] == 32'hA000_0000 + 32'(base + 1), "R12 seg1", mem[129], 32'hA000_0000 + 32'(base + 1));
    chk(mem[256 + 2] == 32'hA000_0000 + 32'(base + 4), "R12 seg2", mem[258], 32'hA000_0000 + 32'(base + 4));
    chk(mem[512] == 32'hA000_0000 + 32'(base + 5), "R12 seg3", mem[512], 32'hA000_0000 + 32'(base + 5));
    stall = 1'b0;
    clear_all();
  endtask

  task automatic t_m2d();
    int n0;
    for (int k = 0; k < 3; k++) mem[192 + k] = 32'h5EED_0000 + 32'(k);
    push(32'h300, 12, 1'b1);
    n0 = dlog_n;
    wr(4'h0, 32'h07);
    wait_idle();
    for (int k = 0; k < 3; k++)
      chk(dlog[n0 + k] == 32'h5EED_0000 + 32'(k), "R12 m2d word", dlog[n0 + k], 32'h5EED_0000 + 32'(k));
    clear_all();
  endtask

  task automatic t_page();
    logic [31:0] s;
    push(32'hFF0, 16, 1'b1);
    wr(4'h0, 32'h05);
    wait_idle();
    rd(4'h4, s);
    chk(s == 32'h2, "R7 exact page end accepted", s, 32'h2);
    clear_all();
    mem[1022] = 32'hDEAD_BEEF;
    push(32'hFF8, 16, 1'b1);
    wr(4'h0, 32'h05);
    wait_idle();
    rd(4'h4, s);
    chk(s == 32'h4, "R7 crossing rejected", s, 32'h4);
    chk(mem[1022] == 32'hDEAD_BEEF, "R7 no access", mem[1022], 32'hDEAD_BEEF);
    chk(irq == 1'b1, "R10 irq on error", 32'(irq), 1);
    clear_all();
    push(32'h500, 8, 1'b0);
    push(32'h1FFC, 8, 1'b0);
    push(32'h600, 4, 1'b1);
    wr(4'h0, 32'h05);
    wait_idle();
    rd(4'h4, s);
    chk(s == 32'h14, "R7 fail index 1", s, 32'h14);
    rd(4'h8, s);
    chk(s == 0, "R7 rest dropped", s, 0);
    clear_all();
    push(32'h500, 6, 1'b1);
    wr(4'h0, 32'h05);
    wait_idle();
    rd(4'h4, s);
    chk(s == 32'h4, "R7 odd length", s, 32'h4);
    clear_all();
    wr(4'h0, 32'h05);
    wait_idle();
    rd(4'h4, s);
    chk(s == 32'h4, "R7 empty queue", s, 32'h4);
    clear_all();
  endtask

  task automatic t_overrun();
    logic [31:0] s; int base;
    stall = 1'b1;
    push(32'h700, 32, 1'b1);
    base = dev_cnt;
    wr(4'h0, 32'h05);
    wr(4'h0, 32'h37);
    wait_idle();
    rd(4'h4, s);
    chk(s == 32'hA, "R11 overrun set", s, 32'hA);
    rd(4'h0, s);
    chk(s == 32'h04, "R11 control unchanged", s, 32'h04);
    chk(mem[448 + 7] == 32'hA000_0000 + 32'(base + 7), "R11 transfer intact", mem[455], 32'hA000_0000 + 32'(base + 7));
    stall = 1'b0;
    clear_all();
  endtask

  task automatic t_irq_off();
    logic [31:0] s;
    push(32'h780, 4, 1'b1);
    wr(4'h0, 32'h01);
    wait_idle();
    rd(4'h4, s);
    chk(s == 32'h2, "R10 done without enable", s, 32'h2);
    chk(irq == 1'b0, "R10 irq gated", 32'(irq), 0);
    clear_all();
  endtask

  task automatic t_full();
    logic [31:0] s;
    for (int k = 0; k < 9; k++) push(32'h900 + 32'(k * 4), 4, 1'b0);
    rd(4'h8, s);
    chk(s == 8, "R3 queue full", s, 8);
    wr(4'h0, 32'h05);
    wait_idle();
    rd(4'h4, s);
    chk(s == 32'h2, "R8 exhausted queue ends chain", s, 32'h2);
    clear_all();
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_m2d();
    t_page();
    t_overrun();
    t_irq_off();
    t_full();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule